// File: doc/BRIEF.md
# Stereo Camera Pair Init Sequencer

This controller brings two image sensors on one two-wire control bus into a lockstepped stereo pair, one as timing master and one as follower. It issues a fixed series of register updates through a command port to a two-wire serial host. Each command names a target: both sensors at once, the master only, or the follower only. It also carries an 8-bit register address and a 16-bit data word. Every update changes only a bit or a small field. To do this the controller reads the current word, replaces only the selected bits and writes the word back.

After the fixed bring-up writes, the controller enters a tuning loop. It programs three skew fields in the master and pulses a soft reset on both sensors. It then reads the master's lockstep status word. If the mismatch flag is clear, the controller reports done. If the flag is set, the skew values advance by one and the loop runs again. When the allowed number of passes is used up, the controller reports fail. An error response from the host also aborts the run with fail.

Top module: `stereo_pair_init_seq`

## Requirements
- R1: While reset is applied and after it is released, with no start seen yet, `cmd_valid`, `busy`, `done` and `fail` are all 0.
- R2: The first eight writes go out in this order (target code 00 = both sensors, 01 = master, 10 = follower; `cmd_write` 1 = write, 0 = read):
  - both sensors, 0xB1, bit 1 cleared;
  - master, 0xB1, bit 0 set;
  - both sensors, 0x07, bit 5 set;
  - both sensors, 0xB3, bit 4 cleared;
  - both sensors, 0xB2, bit 4 cleared;
  - master, 0xB1, bit 0 set;
  - follower, 0xB1, bit 0 cleared;
  - follower, 0x07, bit 6 set.
- R3: Each update is a read followed by a write to the same address. The read goes to the master when the write targets both sensors, and to the write's own target otherwise, so a read never uses target 00. The written word equals the word read, with only the named bits changed.
- R4: The seeds `seed_a`, `seed_b` and `seed_c` are captured at start. Tuning pass p (counted from 0) writes to the master only:
  - 0xB2 bits [2:0] = (seed_a + p) mod 8;
  - 0xB3 bits [2:0] = (seed_b + p) mod 8;
  - 0xB4 bits [1:0] = (seed_c + p) mod 4.
- R5: Each pass then sets bit 0 of 0x0C on both sensors and clears it again, in that order.
- R6: Each pass ends with a read of master register 0xB8. If bit 0 of the returned word (the mismatch flag) is 0, the run ends with `done` = 1.
- R7: If the flag is 1 and fewer than MAX_TRIES passes have run, the loop restarts at the skew writes with p+1. If the flag is still 1 after MAX_TRIES passes (default 4), the run ends with `fail` = 1.
- R8: While `cmd_valid` is 1 and `cmd_ack` is 0, every command field holds its value into the next cycle.
- R9: An acknowledge with `cmd_err` = 1 ends the run with `fail` = 1, and no further command is issued.
- R10: A `start` pulse while `busy` is 1 has no effect. A `start` when idle, done or failed launches a new run from the first write.
- R11: `busy` is 1 while a run is in progress. `done` and `fail` are never 1 together, and each holds until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse |
| seed_a | input | 3 | First skew field seed |
| seed_b | input | 3 | Second skew field seed |
| seed_c | input | 2 | Third skew field seed |
| cmd_valid | output | 1 | Command present |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_target | output | 2 | 00 both, 01 master, 10 follower |
| cmd_addr | output | 8 | Register address |
| cmd_wdata | output | 16 | Write data |
| cmd_ack | input | 1 | Host completion strobe |
| cmd_err | input | 1 | Host error, qualified by ack |
| cmd_rdata | input | 16 | Read data, qualified by ack |
| busy | output | 1 | Run in progress |
| done | output | 1 | Lockstep reached |
| fail | output | 1 | Aborted or retries used up |

## Verification
The bench models both sensors' register files with distinct start patterns, so a merge that reads from the wrong sensor shows up in the follower's copy. It sweeps every first-field seed against every lockstep point. This covers convergence on each of the passes and also runs that use up the pass limit. The final skew fields, the count of status reads and the count of soft-reset pulses then separate an off-by-one in the sweep from one in the retry limit. Other runs vary the acknowledge latency, pulse start in mid-run and inject host errors on a read inside the bring-up and inside the tuning loop.

// File: rtl/stereo_init_pkg.sv
package stereo_init_pkg;

  typedef enum logic [1:0] {
    TGT_ALL = 2'b00,
    TGT_MST = 2'b01,
    TGT_SLV = 2'b10
  } tgt_e;

  typedef struct packed {
    tgt_e        tgt;
    logic [7:0]  addr;
    logic [15:0] mask;
    logic [15:0] value;
  } step_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_PROBE,
    ST_DONE,
    ST_FAIL
  } seq_st_e;

  localparam int unsigned N_STEPS    = 14;
  localparam int unsigned LOOP_FIRST = 8;
  localparam int unsigned PROBE_STEP = 13;

endpackage

// File: rtl/sis_step_rom.sv
module sis_step_rom
  import stereo_init_pkg::*;
#(
  parameter int IDXW = 4
) (
  input  logic [IDXW-1:0] idx,
  input  logic [2:0]      skew_a,
  input  logic [2:0]      skew_b,
  input  logic [1:0]      skew_c,
  output step_t           step
);

  always_comb begin
    step = '{tgt: TGT_MST, addr: 8'h00, mask: 16'h0000, value: 16'h0000};
    case (int'(idx))
      0:  step = '{tgt: TGT_ALL, addr: 8'hB1, mask: 16'h0002, value: 16'h0000};
      1:  step = '{tgt: TGT_MST, addr: 8'hB1, mask: 16'h0001, value: 16'h0001};
      2:  step = '{tgt: TGT_ALL, addr: 8'h07, mask: 16'h0020, value: 16'h0020};
      3:  step = '{tgt: TGT_ALL, addr: 8'hB3, mask: 16'h0010, value: 16'h0000};
      4:  step = '{tgt: TGT_ALL, addr: 8'hB2, mask: 16'h0010, value: 16'h0000};
      5:  step = '{tgt: TGT_MST, addr: 8'hB1, mask: 16'h0001, value: 16'h0001};
      6:  step = '{tgt: TGT_SLV, addr: 8'hB1, mask: 16'h0001, value: 16'h0000};
      7:  step = '{tgt: TGT_SLV, addr: 8'h07, mask: 16'h0040, value: 16'h0040};
      8:  step = '{tgt: TGT_MST, addr: 8'hB2, mask: 16'h0007, value: {13'd0, skew_a}};
      9:  step = '{tgt: TGT_MST, addr: 8'hB3, mask: 16'h0007, value: {13'd0, skew_b}};
      10: step = '{tgt: TGT_MST, addr: 8'hB4, mask: 16'h0003, value: {14'd0, skew_c}};
      11: step = '{tgt: TGT_ALL, addr: 8'h0C, mask: 16'h0001, value: 16'h0001};
      12: step = '{tgt: TGT_ALL, addr: 8'h0C, mask: 16'h0001, value: 16'h0000};
      13: step = '{tgt: TGT_MST, addr: 8'hB8, mask: 16'h0000, value: 16'h0000};
      default: ;
    endcase
  end

endmodule

// File: rtl/sis_skew_sweep.sv
module sis_skew_sweep #(
  parameter int PW = 2
) (
  input  logic [2:0]    seed_a,
  input  logic [2:0]    seed_b,
  input  logic [1:0]    seed_c,
  input  logic [PW-1:0] pass_idx,
  output logic [2:0]    skew_a,
  output logic [2:0]    skew_b,
  output logic [1:0]    skew_c
);

  logic [2:0] step3;

  assign step3  = 3'(pass_idx);
  assign skew_a = seed_a + step3;
  assign skew_b = seed_b + step3;
  assign skew_c = seed_c + step3[1:0];

endmodule

// File: rtl/sis_field_merge.sv
module sis_field_merge #(
  parameter int W = 16
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] value,
  output logic [W-1:0] merged
);

  assign merged = (cur & ~mask) | (value & mask);

endmodule

// File: rtl/stereo_pair_init_seq.sv
module stereo_pair_init_seq
  import stereo_init_pkg::*;
#(
  parameter int MAX_TRIES = 4,
  parameter int FLAG_BIT  = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  seed_a,
  input  logic [2:0]  seed_b,
  input  logic [1:0]  seed_c,
  output logic        cmd_valid,
  output logic        cmd_write,
  output logic [1:0]  cmd_target,
  output logic [7:0]  cmd_addr,
  output logic [15:0] cmd_wdata,
  input  logic        cmd_ack,
  input  logic        cmd_err,
  input  logic [15:0] cmd_rdata,
  output logic        busy,
  output logic        done,
  output logic        fail
);

  localparam int IDXW = $clog2(N_STEPS);
  localparam int PW   = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  seq_st_e         state_q, state_d;
  logic [IDXW-1:0] step_q, step_d;
  logic [PW-1:0]   pass_q, pass_d;
  logic [15:0]     rbuf_q;
  logic [2:0]      seed_a_q, seed_b_q;
  logic [1:0]      seed_c_q;

  logic            idle_like, launch, rbuf_en, last_pass;
  logic [2:0]      skew_a, skew_b;
  logic [1:0]      skew_c;
  step_t           cur_step;
  logic [15:0]     merged;

  assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_FAIL);
  assign launch    = idle_like && start;
  assign rbuf_en   = (state_q == ST_READ) && cmd_ack && !cmd_err;
  assign last_pass = (int'(pass_q) >= MAX_TRIES - 1);

  sis_skew_sweep #(.PW(PW)) u_sweep (
    .seed_a  (seed_a_q),
    .seed_b  (seed_b_q),
    .seed_c  (seed_c_q),
    .pass_idx(pass_q),
    .skew_a  (skew_a),
    .skew_b  (skew_b),
    .skew_c  (skew_c)
  );

  sis_step_rom #(.IDXW(IDXW)) u_rom (
    .idx   (step_q),
    .skew_a(skew_a),
    .skew_b(skew_b),
    .skew_c(skew_c),
    .step  (cur_step)
  );

  sis_field_merge #(.W(16)) u_merge (
    .cur   (rbuf_q),
    .mask  (cur_step.mask),
    .value (cur_step.value),
    .merged(merged)
  );

  // next-state
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    pass_d  = pass_q;
    case (state_q)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start) begin
          state_d = ST_READ;
          step_d  = '0;
          pass_d  = '0;
        end
      end
      ST_READ: begin
        if (cmd_ack) state_d = cmd_err ? ST_FAIL : ST_WRITE;
      end
      ST_WRITE: begin
        if (cmd_ack) begin
          if (cmd_err) begin
            state_d = ST_FAIL;
          end else begin
            step_d  = step_q + IDXW'(1);
            state_d = (int'(step_q) == int'(PROBE_STEP) - 1) ? ST_PROBE : ST_READ;
          end
        end
      end
      ST_PROBE: begin
        if (cmd_ack) begin
          if (cmd_err)                     state_d = ST_FAIL;
          else if (!cmd_rdata[FLAG_BIT])   state_d = ST_DONE;
          else if (last_pass)              state_d = ST_FAIL;
          else begin
            pass_d  = pass_q + PW'(1);
            step_d  = IDXW'(LOOP_FIRST);
            state_d = ST_READ;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      pass_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      pass_q  <= pass_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rbuf_q <= '0;
    end else if (rbuf_en) begin
      rbuf_q <= cmd_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      seed_a_q <= '0;
      seed_b_q <= '0;
      seed_c_q <= '0;
    end else if (launch) begin
      seed_a_q <= seed_a;
      seed_b_q <= seed_b;
      seed_c_q <= seed_c;
    end
  end

  // command port
  assign cmd_valid  = (state_q == ST_READ) || (state_q == ST_WRITE) || (state_q == ST_PROBE);
  assign cmd_write  = (state_q == ST_WRITE);
  assign cmd_target = ((state_q == ST_WRITE) || (cur_step.tgt != TGT_ALL)) ? cur_step.tgt : TGT_MST;
  assign cmd_addr   = cur_step.addr;
  assign cmd_wdata  = (state_q == ST_WRITE) ? merged : 16'h0000;
  assign busy       = cmd_valid;
  assign done       = (state_q == ST_DONE);
  assign fail       = (state_q == ST_FAIL);

  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid && !cmd_ack) |=> (cmd_valid && $stable(cmd_write) && $stable(cmd_target)
                                 && $stable(cmd_addr) && $stable(cmd_wdata)));

  // R3
  rd_target_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid && !cmd_write) |-> (cmd_target != 2'b00));

  // R9
  err_abort_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid && cmd_ack && cmd_err) |=> (fail && !cmd_valid));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && start && !cmd_ack) |=> (busy && $stable(cmd_addr)));

  // R11
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> (!fail && !busy));

  // R7
  retry_limit_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((state_q == ST_PROBE) && cmd_ack && !cmd_err && cmd_rdata[FLAG_BIT] && last_pass) |=> fail);

endmodule

// File: tb/sim_stereo_pair_init_seq.sv
`timescale 1ns/1ps
module sim_stereo_pair_init_seq;

  localparam int TRIES = 4;

  logic        clk = 1'b0;
  logic        rst_n, start;
  logic [2:0]  seed_a, seed_b;
  logic [1:0]  seed_c;
  logic        cmd_valid, cmd_write, cmd_ack, cmd_err;
  logic [1:0]  cmd_target;
  logic [7:0]  cmd_addr;
  logic [15:0] cmd_wdata, cmd_rdata;
  logic        busy, done, fail;

  always #2.5 clk = ~clk;

  stereo_pair_init_seq #(.MAX_TRIES(TRIES), .FLAG_BIT(0)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .seed_a(seed_a), .seed_b(seed_b), .seed_c(seed_c),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_target(cmd_target),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_ack(cmd_ack), .cmd_err(cmd_err), .cmd_rdata(cmd_rdata),
    .busy(busy), .done(done), .fail(fail)
  );

  int n_checks = 0;
  int n_fail   = 0;

  logic [15:0] mreg [256];
  logic [15:0] sreg [256];
  int lat, good_a, err_at;
  int n_cmd, n_wr, n_probe, n_rst_set, n_rst_clr, viol_stab, viol_rd, n_log;
  logic [1:0] log_tgt  [16];
  logic [7:0] log_addr [16];

  logic        h_w, h_e;
  logic [1:0]  h_t;
  logic [7:0]  h_a;
  logic [15:0] h_d, h_r;

  function automatic logic [15:0] om(int a);
    return {8'(a), ~8'(a)} ^ 16'h3C00;
  endfunction
  function automatic logic [15:0] os(int a);
    return {~8'(a), 8'(a)};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // host and two-sensor register model
  initial begin
    cmd_ack = 1'b0; cmd_err = 1'b0; cmd_rdata = 16'h0;
    forever begin
      @(negedge clk);
      cmd_ack = 1'b0; cmd_err = 1'b0;
      if (rst_n && cmd_valid) begin
        h_w = cmd_write; h_t = cmd_target; h_a = cmd_addr; h_d = cmd_wdata;
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          if (cmd_valid !== 1'b1 || cmd_write !== h_w || cmd_target !== h_t ||
              cmd_addr !== h_a || cmd_wdata !== h_d) viol_stab++;
        end
        n_cmd++;
        h_e = (n_cmd == err_at);
        h_r = 16'h0;
        if (!h_w) begin
          if (h_t == 2'b00) viol_rd++;
          h_r = (h_t == 2'b10) ? sreg[h_a] : mreg[h_a];
          if (h_a == 8'hB8) begin
            n_probe++;
            h_r[0] = (mreg[8'hB2][2:0] != 3'(good_a));
          end
        end else if (!h_e) begin
          n_wr++;
          if (n_log < 16) begin
            log_tgt[n_log] = h_t; log_addr[n_log] = h_a; n_log++;
          end
          if (h_t != 2'b10) mreg[h_a] = h_d;
          if (h_t != 2'b01) sreg[h_a] = h_d;
          if (h_a == 8'h0C) begin
            if (h_d[0]) n_rst_set++; else n_rst_clr++;
          end
        end
        cmd_err = h_e; cmd_rdata = h_r; cmd_ack = 1'b1;
      end
    end
  end

  task automatic prep(int sa, int good, int latency, int errn);
    for (int a = 0; a < 256; a++) begin mreg[a] = om(a); sreg[a] = os(a); end
    lat = latency; good_a = good; err_at = errn;
    n_cmd = 0; n_wr = 0; n_probe = 0; n_rst_set = 0; n_rst_clr = 0;
    viol_stab = 0; viol_rd = 0; n_log = 0;
    seed_a = 3'(sa); seed_b = 3'(sa) ^ 3'd5; seed_c = 2'(sa);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 5000; i++) begin
      if (done || fail) break;
      @(negedge clk);
    end
  endtask

  task automatic err_case(int errn);
    prep(0, 0, 1, errn);
    wait_end();
    chk("R9", "fail after host error", fail, 1);
    chk("R9", "done after host error", done, 0);
    repeat (20) @(negedge clk);
    chk("R9", "commands issued", n_cmd, errn);
    chk("R9", "valid after abort", cmd_valid, 0);
  endtask

  task automatic sweep_case(int sa, int good, bit mid_start);
    int k, passes, ok;
    logic [15:0] ea, eb, ec;
    logic [1:0]  exp_t [13];
    logic [7:0]  exp_a [13];
    exp_t = '{2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd2, 2'd1, 2'd1, 2'd1, 2'd0, 2'd0};
    exp_a = '{8'hB1, 8'hB1, 8'h07, 8'hB3, 8'hB2, 8'hB1, 8'hB1, 8'h07,
              8'hB2, 8'hB3, 8'hB4, 8'h0C, 8'h0C};
    k      = (good - sa + 8) % 8;
    ok     = (k < TRIES) ? 1 : 0;
    passes = ok ? k + 1 : TRIES;
    prep(sa, good, (sa + good) % 3, -1);
    if (mid_start) begin
      repeat (12) @(negedge clk);
      chk("R10", "busy mid-run", busy, 1);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    wait_end();
    chk("R6", "done", done, 32'(ok));
    chk("R7", "fail", fail, 32'(1 - ok));
    chk("R7", "status reads", n_probe, passes);
    chk("R5", "soft reset set writes", n_rst_set, passes);
    chk("R5", "soft reset clear writes", n_rst_clr, passes);
    chk("R10", "write count", n_wr, 8 + 5 * passes);
    chk("R3", "reads with target 00", viol_rd, 0);
    chk("R8", "fields moved while waiting", viol_stab, 0);
    for (int i = 0; i < 13; i++) begin
      chk("R2", "write target order", log_tgt[i], exp_t[i]);
      chk("R2", "write address order", log_addr[i], exp_a[i]);
    end
    ea = 16'((sa + passes - 1) % 8);
    eb = 16'(((sa ^ 5) + passes - 1) % 8);
    ec = 16'(((sa & 3) + passes - 1) % 4);
    chk("R3", "master 0xB1", mreg[8'hB1], (om(8'hB1) & ~16'h0002) | 16'h0001);
    chk("R3", "follower 0xB1", sreg[8'hB1], om(8'hB1) & ~16'h0003);
    chk("R2", "master 0x07", mreg[8'h07], om(8'h07) | 16'h0020);
    chk("R2", "follower 0x07", sreg[8'h07], om(8'h07) | 16'h0060);
    chk("R4", "master 0xB2", mreg[8'hB2], (om(8'hB2) & ~16'h0017) | ea);
    chk("R3", "follower 0xB2", sreg[8'hB2], om(8'hB2) & ~16'h0010);
    chk("R4", "master 0xB3", mreg[8'hB3], (om(8'hB3) & ~16'h0017) | eb);
    chk("R3", "follower 0xB3", sreg[8'hB3], om(8'hB3) & ~16'h0010);
    chk("R4", "master 0xB4", mreg[8'hB4], (om(8'hB4) & ~16'h0003) | ec);
    chk("R4", "follower 0xB4", sreg[8'hB4], os(8'hB4));
    chk("R5", "master 0x0C", mreg[8'h0C], om(8'h0C) & ~16'h0001);
    chk("R5", "follower 0x0C", sreg[8'h0C], om(8'h0C) & ~16'h0001);
    repeat (8) @(negedge clk);
    chk("R11", "end state held", {done, fail, busy, cmd_valid}, {1'(ok), 1'(1 - ok), 2'b00});
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; seed_a = '0; seed_b = '0; seed_c = '0;
    lat = 0; good_a = 0; err_at = -1;
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset", {cmd_valid, busy, done, fail}, 4'b0000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", "outputs after release", {cmd_valid, busy, done, fail}, 4'b0000);
    err_case(3);
    err_case(17);
    for (int sa = 0; sa < 8; sa++)
      for (int g = 0; g < 8; g++)
        sweep_case(sa, g, g == 3);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule